// File: doc/BRIEF.md
# I2C Bus Condition and Acknowledge Monitor

This block listens to the clock and data lines of a two-wire serial bus from inside a serial controller. It drives nothing on the bus and shifts no data. It brings both lines into the system clock domain and finds start and stop conditions. It keeps a flag that shows whether the bus is currently owned by a transfer. It also finds the acknowledge slot of every byte by counting clock rises.

A start or a stop raises one shared pulse, `cond_evt`, meant as a single interrupt source. On the ninth rising clock edge of a byte, the level of the data line picks the event. A low level gives an acknowledge pulse and a matching DMA request strobe. A high level gives a no-acknowledge pulse.

The surrounding controller raises `byte_active` while a byte transfer is running, which lets the monitor count clock rises. Dropping `mon_en` parks the whole block in its idle state.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A start condition is a high-to-low change of the data line while the clock line is high in both the old and the new sample. It produces a one-cycle `cond_evt` pulse on the third rising system clock edge after the change is first sampled, which is two synchronizer stages plus one output register.
- R2: A stop condition is a low-to-high change of the data line while the clock line stays high. It produces the same one-cycle `cond_evt` pulse with the same latency as R1.
- R3: After reset, every output is 0. `bus_busy` becomes 1 in the cycle `cond_evt` reports a start and becomes 0 in the cycle it reports a stop. Otherwise it holds its value.
- R4: While `byte_active` is 1, the monitor counts rising edges of the synchronized clock line. The count returns to zero when `byte_active` is 0, on any start or stop, and after the ninth rise.
- R5: On the ninth counted rise, if the data line is low, `ack_evt` and `dma_req` pulse together for exactly one cycle, with the latency of R1.
- R6: On the ninth counted rise, if the data line is high, `nack_evt` pulses for one cycle and neither `ack_evt` nor `dma_req` is raised.
- R7: While `mon_en` is 0, no event or strobe is raised, `bus_busy` is 0, and the rise count is cleared.
- R8: Changes of the data line while the clock line is low raise no `cond_evt` and leave `bus_busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mon_en | input | 1 | Monitor enable; 0 holds the block idle |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| byte_active | input | 1 | High while a byte transfer is running; enables rise counting |
| cond_evt | output | 1 | One-cycle pulse on a start or a stop |
| ack_evt | output | 1 | One-cycle pulse when the ninth clock sees the data line low |
| nack_evt | output | 1 | One-cycle pulse when the ninth clock sees the data line high |
| bus_busy | output | 1 | Set by start, cleared by stop |
| dma_req | output | 1 | One-cycle DMA request strobe issued with every acknowledge |

## Verification
The hardest case to reach is a byte cut short by a repeated start. The rise count must restart from zero rather than carry on from the aborted byte. The stimulus clocks five bits, then raises the data line with the clock low, raises the clock, and drops the data line. It then clocks exactly nine more bits and expects the acknowledge on the last one only. A second sequence drops `byte_active` between clock pulses so that the clear-on-idle path is exercised separately from the clear-on-condition path.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  typedef struct packed {
    logic scl;
    logic sda;
  } line_t;

  localparam int unsigned LINE_W = $bits(line_t);
  localparam line_t LINE_IDLE = '{scl: 1'b1, sda: 1'b1};
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond
  import i2cmon_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  line_t cur,
  output logic  start_hit,
  output logic  stop_hit,
  output logic  scl_rise,
  output logic  busy
);
  line_t prev_q;
  logic  busy_d, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= LINE_IDLE;
    else        prev_q <= cur;
  end

  always_comb begin
    start_hit = en && cur.scl && prev_q.scl &&  prev_q.sda && !cur.sda;
    stop_hit  = en && cur.scl && prev_q.scl && !prev_q.sda &&  cur.sda;
    scl_rise  = en && cur.scl && !prev_q.scl;
  end

  always_comb begin
    busy_d = busy_q;
    if (!en)           busy_d = 1'b0;
    else if (start_hit) busy_d = 1'b1;
    else if (stop_hit)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;
endmodule

// File: rtl/i2cmon_slot.sv
module i2cmon_slot #(
  parameter int unsigned SLOT_CLOCKS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic byte_active,
  input  logic clear,
  input  logic scl_rise,
  input  logic sda,
  output logic ack_hit,
  output logic nack_hit
);
  localparam int unsigned CNT_W = $clog2(SLOT_CLOCKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CLOCKS - 1);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             slot;

  always_comb begin
    slot     = en && byte_active && !clear && scl_rise && (cnt_q == LAST);
    ack_hit  = slot && !sda;
    nack_hit = slot &&  sda;
    cnt_d    = cnt_q;
    if (!en || !byte_active || clear) cnt_d = '0;
    else if (slot)                    cnt_d = '0;
    else if (scl_rise)                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SLOT_CLOCKS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic scl_in,
  input  logic sda_in,
  input  logic byte_active,
  output logic cond_evt,
  output logic ack_evt,
  output logic nack_evt,
  output logic bus_busy,
  output logic dma_req
);
  line_t raw, cur;
  logic  start_hit, stop_hit, scl_rise, busy;
  logic  ack_hit, nack_hit;
  logic  cond_d, ack_d, nack_d, dma_d;
  logic  cond_q, ack_q, nack_q, dma_q;

  assign raw = '{scl: scl_in, sda: sda_in};

  i2cmon_sync #(
    .WIDTH  (LINE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw),
    .dout (cur)
  );

  i2cmon_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (mon_en),
    .cur      (cur),
    .start_hit(start_hit),
    .stop_hit (stop_hit),
    .scl_rise (scl_rise),
    .busy     (busy)
  );

  i2cmon_slot #(.SLOT_CLOCKS(SLOT_CLOCKS)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mon_en),
    .byte_active(byte_active),
    .clear      (start_hit | stop_hit),
    .scl_rise   (scl_rise),
    .sda        (cur.sda),
    .ack_hit    (ack_hit),
    .nack_hit   (nack_hit)
  );

  always_comb begin
    cond_d = start_hit | stop_hit;
    ack_d  = ack_hit;
    nack_d = nack_hit;
    dma_d  = ack_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      ack_q  <= 1'b0;
      nack_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      cond_q <= cond_d;
      ack_q  <= ack_d;
      nack_q <= nack_d;
      dma_q  <= dma_d;
    end
  end

  assign cond_evt = cond_q;
  assign ack_evt  = ack_q;
  assign nack_evt = nack_q;
  assign dma_req  = dma_q;
  assign bus_busy = busy;
endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic byte_active,
  input logic cond_evt,
  input logic ack_evt,
  input logic nack_evt,
  input logic bus_busy,
  input logic dma_req
);
  // R1
  cond_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_evt |=> !cond_evt);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> cond_evt);

  // R3
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> (cond_evt || !$past(mon_en)));

  // R4
  slot_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt || nack_evt) |-> $past(byte_active));

  // R5
  ack_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |-> dma_req);

  // R6
  nack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cond_evt, ack_evt, nack_evt}));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mon_en) |-> !(cond_evt || ack_evt || nack_evt || dma_req || bus_busy));
endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mon_en     (mon_en),
  .byte_active(byte_active),
  .cond_evt   (cond_evt),
  .ack_evt    (ack_evt),
  .nack_evt   (nack_evt),
  .bus_busy   (bus_busy),
  .dma_req    (dma_req)
);

// File: tb/i2c_bus_monitor_test.sv
`timescale 1ns/1ps
module i2c_bus_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en = 1'b0;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic byte_active = 1'b0;
  logic cond_evt, ack_evt, nack_evt, bus_busy, dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int n_cond = 0, n_ack = 0, n_nack = 0, n_dma = 0;

  always #4 clk = ~clk;

  i2c_bus_monitor uut (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en),
    .scl_in(scl_in), .sda_in(sda_in), .byte_active(byte_active),
    .cond_evt(cond_evt), .ack_evt(ack_evt), .nack_evt(nack_evt),
    .bus_busy(bus_busy), .dma_req(dma_req)
  );

  // behavioural reference: queues of sampled line levels
  bit q_scl[$];
  bit q_sda[$];
  bit m_cond, m_ack, m_nack, m_busy, m_dma;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_scl.delete(); q_sda.delete();
      m_cond = 0; m_ack = 0; m_nack = 0; m_busy = 0; m_dma = 0; m_cnt = 0;
    end else begin
      bit a_scl, a_sda, b_scl, b_sda, st, sp, rise;
      q_scl.push_front(scl_in);
      q_sda.push_front(sda_in);
      if (q_scl.size() > 4) begin
        void'(q_scl.pop_back()); void'(q_sda.pop_back());
      end
      a_scl = (q_scl.size() > 2) ? q_scl[2] : 1'b1;
      a_sda = (q_sda.size() > 2) ? q_sda[2] : 1'b1;
      b_scl = (q_scl.size() > 3) ? q_scl[3] : 1'b1;
      b_sda = (q_sda.size() > 3) ? q_sda[3] : 1'b1;
      st   = a_scl && b_scl && b_sda && !a_sda;
      sp   = a_scl && b_scl && !b_sda && a_sda;
      rise = a_scl && !b_scl;
      m_cond = 0; m_ack = 0; m_nack = 0; m_dma = 0;
      if (!mon_en) begin
        m_busy = 0; m_cnt = 0;
      end else begin
        m_cond = st || sp;
        if (st) m_busy = 1;
        else if (sp) m_busy = 0;
        if (st || sp || !byte_active) m_cnt = 0;
        else if (rise) begin
          if (m_cnt == 8) begin
            m_ack = !a_sda; m_dma = !a_sda; m_nack = a_sda; m_cnt = 0;
          end else m_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cond_evt == m_cond, "R1/R2/R8 cond_evt", cond_evt, m_cond);
      chk(bus_busy == m_busy, "R3 bus_busy", bus_busy, m_busy);
      chk(ack_evt == m_ack,   "R5 ack_evt", ack_evt, m_ack);
      chk(nack_evt == m_nack, "R6 nack_evt", nack_evt, m_nack);
      chk(dma_req == m_dma,   "R5 dma_req", dma_req, m_dma);
      n_cond += cond_evt; n_ack += ack_evt; n_nack += nack_evt; n_dma += dma_req;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input bit b);
    scl_in = 0; hold(3);
    sda_in = b; hold(3);
    scl_in = 1; hold(6);
    scl_in = 0;
  endtask

  task automatic send_byte(input bit [7:0] d, input bit ackbit);
    for (int i = 7; i >= 0; i--) bit_clk(d[i]);
    bit_clk(ackbit);
    hold(3);
  endtask

  task automatic do_start;
    scl_in = 0; hold(3);
    sda_in = 1; hold(3);
    scl_in = 1; hold(6);
    sda_in = 0; hold(6);
    scl_in = 0; hold(3);
  endtask

  task automatic do_stop;
    scl_in = 0; hold(3);
    sda_in = 0; hold(3);
    scl_in = 1; hold(6);
    sda_in = 1; hold(8);
  endtask

  initial begin
    hold(3);
    chk({cond_evt, ack_evt, nack_evt, bus_busy, dma_req} == 5'b0, "R3 reset state",
        {cond_evt, ack_evt, nack_evt, bus_busy, dma_req}, 0);
    rst_n = 1; mon_en = 1; hold(6);

    // R1 R5: start then acknowledged byte
    do_start();
    chk(bus_busy == 1, "R3 busy after start", bus_busy, 1);
    chk(n_cond == 1, "R1 start pulse count", n_cond, 1);
    byte_active = 1;
    send_byte(8'hA5, 1'b0);
    chk(n_ack == 1 && n_dma == 1, "R5 ack and dma count", n_ack + n_dma, 2);

    // R6: not acknowledged byte
    send_byte(8'h3C, 1'b1);
    chk(n_nack == 1 && n_ack == 1, "R6 nack count", n_nack, 1);

    // R4: repeated start after five clocks restarts the count
    for (int i = 0; i < 5; i++) bit_clk(i[0]);
    do_start();
    chk(n_cond == 2, "R4 repeated start seen", n_cond, 2);
    send_byte(8'hF0, 1'b0);
    chk(n_ack == 2, "R4 count restarted after start", n_ack, 2);

    // R4: byte_active low clears count
    for (int i = 0; i < 4; i++) bit_clk(1'b1);
    byte_active = 0; hold(4); byte_active = 1;
    send_byte(8'h0F, 1'b0);
    chk(n_ack == 3 && n_nack == 1, "R4 clear on idle byte", n_ack, 3);

    // R2: stop
    byte_active = 0;
    do_stop();
    chk(bus_busy == 0, "R2 busy cleared by stop", bus_busy, 0);
    chk(n_cond == 3, "R2 stop pulse count", n_cond, 3);

    // R7: disabled monitor ignores everything
    mon_en = 0;
    do_start(); byte_active = 1;
    send_byte(8'h55, 1'b0);
    chk(bus_busy == 0, "R7 busy held low", bus_busy, 0);
    byte_active = 0;
    do_stop();
    chk(n_cond == 3 && n_ack == 3, "R7 no events when disabled", n_cond, 3);
    mon_en = 1; hold(6);

    // R8: data toggles with clock low
    scl_in = 0; hold(4);
    for (int i = 0; i < 6; i++) begin sda_in = ~sda_in; hold(4); end
    chk(n_cond == 3 && bus_busy == 0, "R8 no condition with clock low", n_cond, 3);
    scl_in = 1; sda_in = 1; hold(8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule